// File: doc/BRIEF.md
# Dual-Clock Cell FIFO with Cell Discard

This block carries 16-bit words from a write clock domain into a read clock domain that runs on a clock of its own. Data is managed in whole cells. The writer marks the last word of each cell. It can also flag any word of a cell for discard. A cell becomes visible to the reader only once its last word has been written without a discard flag. A discarded cell is rolled back completely, so none of its words are ever read.

The cell length is a static configuration, `cell_bytes`, from 16 to 128 bytes. A cell therefore holds `cell_bytes/2` words. The write side shows whether one whole cell of space remains, so the writer can check this before it starts a cell. The read side shows whether at least one complete cell is waiting. Capacity is `2**ADDR_W` words. The default of 1024 words covers a 1.5 KB (768-word) requirement.

Only committed state crosses the clock boundary. The writer keeps a speculative pointer that moves on every accepted word, and a committed pointer that moves at each good end-of-cell. A published copy of the committed pointer chases it one step per write clock. That copy is Gray coded and passed through two flops into the read domain. The read pointer crosses back to the write domain in the same way.

Top module: `cell_fifo_dc`

## Requirements
- R1: A word written with `wr_eoc`=1 and `wr_drop`=0 commits every word accepted since the previous commit. The committed words are returned on `rd_data` in write order. Each returned word comes with `rd_valid`=1 in the read cycle after its `rd_en`.
- R2: A word written with `wr_drop`=1 discards itself and every uncommitted word before it. The next word written is stored right after the last committed word.
- R3: A word offered while the store holds `2**ADDR_W` uncommitted or unread words is ignored. It is never read back.
- R4: `rd_en` is ignored while no committed unread word exists. In that case `rd_valid` stays 0 and the read position does not move.
- R5: `rd_cell_ready` is 1 when the committed unread words number at least `cell_bytes/2`, and 0 otherwise. It follows a change after a few read-clock cycles of synchronization delay.
- R6: `wr_space` is 1 when free words number at least `cell_bytes/2`, and 0 otherwise. Free words are the capacity minus written-but-unread words, counting uncommitted ones.
- R7: Words of a cell whose end has not yet been written cannot be read. They do not count towards `rd_cell_ready`.
- R8: While `rst` is high, `wr_space`, `rd_cell_ready` and `rd_valid` are 0. After reset the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Offer a word this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_eoc | input | 1 | Word is the last of its cell |
| wr_drop | input | 1 | Discard the current cell |
| wr_space | output | 1 | At least one cell of free words |
| rd_clk | input | 1 | Read domain clock |
| rd_en | input | 1 | Request the next committed word |
| rd_data | output | DATA_W | Returned word |
| rd_valid | output | 1 | `rd_data` holds a word read the previous cycle |
| rd_cell_ready | output | 1 | At least one complete cell is readable |
| cell_bytes | input | 8 | Static cell length in bytes (even, 16..128) |

## Verification
A wrong speculative or committed pointer shows up in the read stream itself. A rollback to the wrong point either leaks dropped words or loses good ones, and the next cell read reveals this word by word. A miscounted occupancy flips `rd_cell_ready` or `wr_space` at the wrong cell boundary. This is visible a few cycles after synchronization, so the tests compare both flags against the known count of written, committed and read words. An overflow or underflow fault shows as an extra or missing word when the store is drained to empty and `rd_en` is pressed once more.

// File: rtl/cell_fifo_pkg.sv
package cell_fifo_pkg;
  localparam int GRAY_MAX_W = 32;

  function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/cell_fifo_ptr_xing.sv
// Moves a pointer that steps by at most one per source clock into another domain.
module cell_fifo_ptr_xing #(
  parameter int PW = 11
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);
  import cell_fifo_pkg::*;

  logic [PW-1:0] gray_q;
  logic [PW-1:0] meta_q, stab_q;
  logic [GRAY_MAX_W-1:0] conv;

  always_ff @(posedge src_clk) begin
    if (rst) gray_q <= '0;
    else     gray_q <= PW'(to_gray(GRAY_MAX_W'(src_bin)));
  end

  assign conv = from_gray(GRAY_MAX_W'(stab_q));

  always_ff @(posedge dst_clk) begin
    if (rst) begin
      meta_q  <= '0;
      stab_q  <= '0;
      dst_bin <= '0;
    end else begin
      meta_q  <= gray_q;
      stab_q  <= meta_q;
      dst_bin <= conv[PW-1:0];
    end
  end
endmodule

// File: rtl/cell_fifo_ram.sv
module cell_fifo_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cell_fifo_wr_ctl.sv
module cell_fifo_wr_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_eoc,
  input  logic            wr_drop,
  input  logic [ADDR_W:0] rd_ptr_sync,
  input  logic [ADDR_W:0] cell_words,
  output logic [ADDR_W:0] spec_ptr,
  output logic [ADDR_W:0] commit_ptr,
  output logic [ADDR_W:0] pub_ptr,
  output logic            mem_we,
  output logic            wr_space
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic [PW-1:0] used, spec_n, free_n;
  logic          full, accept;

  assign used   = spec_ptr - rd_ptr_sync;
  assign full   = (used == DEPTH_P);
  assign accept = wr_en && !full;
  assign mem_we = accept && !wr_drop;

  always_comb begin
    spec_n = spec_ptr;
    if (accept) spec_n = wr_drop ? commit_ptr : spec_ptr + 1'b1;
  end

  assign free_n = DEPTH_P - (spec_n - rd_ptr_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_ptr   <= '0;
      commit_ptr <= '0;
      pub_ptr    <= '0;
      wr_space   <= 1'b0;
    end else begin
      spec_ptr <= spec_n;
      if (accept && wr_eoc && !wr_drop) commit_ptr <= spec_ptr + 1'b1;
      if (pub_ptr != commit_ptr) pub_ptr <= pub_ptr + 1'b1;
      wr_space <= (free_n >= cell_words);
    end
  end
endmodule

// File: rtl/cell_fifo_rd_ctl.sv
module cell_fifo_rd_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [ADDR_W:0] wr_ptr_sync,
  input  logic [ADDR_W:0] cell_words,
  output logic [ADDR_W:0] rd_ptr,
  output logic            mem_re,
  output logic            rd_valid,
  output logic            rd_cell_ready
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] avail, avail_n;

  assign avail   = wr_ptr_sync - rd_ptr;
  assign mem_re  = rd_en && (avail != '0);
  assign avail_n = avail - PW'(mem_re);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr        <= '0;
      rd_valid      <= 1'b0;
      rd_cell_ready <= 1'b0;
    end else begin
      if (mem_re) rd_ptr <= rd_ptr + 1'b1;
      rd_valid      <= mem_re;
      rd_cell_ready <= (avail_n >= cell_words);
    end
  end
endmodule

// File: rtl/cell_fifo_dc.sv
module cell_fifo_dc #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              rst,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eoc,
  input  logic              wr_drop,
  output logic              wr_space,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_cell_ready,
  input  logic [7:0]        cell_bytes
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] cell_words;
  logic [PW-1:0] spec_ptr, commit_ptr, pub_ptr, rd_ptr;
  logic [PW-1:0] wr_ptr_sync, rd_ptr_sync;
  logic          mem_we, mem_re;
  logic          unused_lsb;

  assign cell_words = PW'(cell_bytes[7:1]);
  assign unused_lsb = cell_bytes[0];

  cell_fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(rst), .wr_en(wr_en), .wr_eoc(wr_eoc), .wr_drop(wr_drop),
    .rd_ptr_sync(rd_ptr_sync), .cell_words(cell_words),
    .spec_ptr(spec_ptr), .commit_ptr(commit_ptr), .pub_ptr(pub_ptr),
    .mem_we(mem_we), .wr_space(wr_space)
  );

  cell_fifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_en(rd_en), .wr_ptr_sync(wr_ptr_sync),
    .cell_words(cell_words), .rd_ptr(rd_ptr), .mem_re(mem_re),
    .rd_valid(rd_valid), .rd_cell_ready(rd_cell_ready)
  );

  cell_fifo_ptr_xing #(.PW(PW)) u_w2r (
    .src_clk(wr_clk), .dst_clk(rd_clk), .rst(rst),
    .src_bin(pub_ptr), .dst_bin(wr_ptr_sync)
  );

  cell_fifo_ptr_xing #(.PW(PW)) u_r2w (
    .src_clk(rd_clk), .dst_clk(wr_clk), .rst(rst),
    .src_bin(rd_ptr), .dst_bin(rd_ptr_sync)
  );

  cell_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .we(mem_we), .waddr(spec_ptr[ADDR_W-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .re(mem_re), .raddr(rd_ptr[ADDR_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/cell_fifo_dc_chk.sv
module cell_fifo_dc_chk #(
  parameter int ADDR_W = 10
) (
  input logic            wr_clk,
  input logic            rd_clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wr_eoc,
  input logic            wr_drop,
  input logic            rd_en,
  input logic            rd_valid,
  input logic [ADDR_W:0] spec_ptr,
  input logic [ADDR_W:0] commit_ptr,
  input logic [ADDR_W:0] pub_ptr,
  input logic [ADDR_W:0] rd_ptr_sync,
  input logic [ADDR_W:0] wr_ptr_sync,
  input logic [ADDR_W:0] rd_ptr
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic wr_full;
  assign wr_full = ((spec_ptr - rd_ptr_sync) == DEPTH_P);

  // R1: committed pointer moves only on a clean end-of-cell word
  p_commit_on_eoc_r1: assert property (@(posedge wr_clk) disable iff (rst)
    (commit_ptr != $past(commit_ptr)) |-> $past(wr_en && wr_eoc && !wr_drop));

  // R1: published pointer advances by at most one per write clock
  p_pub_step_r1: assert property (@(posedge wr_clk) disable iff (rst)
    ((pub_ptr - $past(pub_ptr)) <= PW'(1)));

  // R2: an accepted drop returns the speculative pointer to the commit point
  p_drop_rollback_r2: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && wr_drop && !wr_full) |=> (spec_ptr == commit_ptr));

  // R3: written-but-unread words never exceed capacity
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (rst)
    ((spec_ptr - rd_ptr_sync) <= DEPTH_P));

  // R4: read pointer never passes the synchronized committed pointer
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (rst)
    ((wr_ptr_sync - rd_ptr) <= DEPTH_P));

  // R4: a returned word always answers a request
  p_valid_needs_req_r4: assert property (@(posedge rd_clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind cell_fifo_dc cell_fifo_dc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wr_en(wr_en), .wr_eoc(wr_eoc), .wr_drop(wr_drop),
  .rd_en(rd_en), .rd_valid(rd_valid),
  .spec_ptr(spec_ptr), .commit_ptr(commit_ptr), .pub_ptr(pub_ptr),
  .rd_ptr_sync(rd_ptr_sync), .wr_ptr_sync(wr_ptr_sync), .rd_ptr(rd_ptr)
);

// File: tb/cell_fifo_dc_tb.sv
`timescale 1ns/1ps
module cell_fifo_dc_tb;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic rst, wr_clk, rd_clk;
  logic wr_en, wr_eoc, wr_drop, rd_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic wr_space, rd_valid, rd_cell_ready;
  logic [7:0] cell_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cell_fifo_dc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eoc(wr_eoc), .wr_drop(wr_drop), .wr_space(wr_space),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_cell_ready(rd_cell_ready), .cell_bytes(cell_bytes)
  );

  initial wr_clk = 0;
  always #5 wr_clk = ~wr_clk;
  initial rd_clk = 0;
  always #7 rd_clk = ~rd_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic put_cell(input int base, input int n, input int drop_at, input bit eoc);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en   = 1;
      wr_data = DATA_W'(base + i);
      wr_eoc  = eoc && (i == n - 1);
      wr_drop = (i == drop_at);
    end
    @(negedge wr_clk);
    wr_en = 0; wr_eoc = 0; wr_drop = 0;
  endtask

  task automatic get_words(input int base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
      check(rd_valid === 1'b1, req, int'(rd_valid), 1);
      check(rd_data === DATA_W'(base + i), req, int'(rd_data), (base + i) & 16'hFFFF);
    end
  endtask

  task automatic get_none(input string req);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    check(rd_valid === 1'b0, req, int'(rd_valid), 0);
  endtask

  task automatic t_reset();
    rst = 1; wr_en = 0; wr_eoc = 0; wr_drop = 0; wr_data = '0; rd_en = 0;
    cell_bytes = 8'd16;
    repeat (6) @(negedge rd_clk);
    check(wr_space === 1'b0, "R8 space in reset", int'(wr_space), 0);
    check(rd_cell_ready === 1'b0, "R8 ready in reset", int'(rd_cell_ready), 0);
    check(rd_valid === 1'b0, "R8 valid in reset", int'(rd_valid), 0);
    rst = 0;
    settle();
    check(wr_space === 1'b1, "R8 R6 space after reset", int'(wr_space), 1);
    check(rd_cell_ready === 1'b0, "R8 empty after reset", int'(rd_cell_ready), 0);
    get_none("R4 read of empty store");
  endtask

  task automatic t_single_cell();
    put_cell(16'h100, 8, -1, 1);
    settle();
    check(rd_cell_ready === 1'b1, "R5 one cell ready", int'(rd_cell_ready), 1);
    get_words(16'h100, 8, "R1 single cell data");
    settle();
    check(rd_cell_ready === 1'b0, "R5 ready drops after read", int'(rd_cell_ready), 0);
  endtask

  task automatic t_drop();
    put_cell(16'h200, 6, 5, 0);
    settle();
    check(rd_cell_ready === 1'b0, "R2 dropped cell invisible", int'(rd_cell_ready), 0);
    get_none("R2 no dropped word readable");
    put_cell(16'h300, 8, -1, 1);
    settle();
    check(rd_cell_ready === 1'b1, "R2 cell after drop ready", int'(rd_cell_ready), 1);
    get_words(16'h300, 8, "R2 data after drop");
    get_none("R2 nothing left after drop");
  endtask

  task automatic t_partial();
    put_cell(16'h400, 4, -1, 0);
    settle();
    check(rd_cell_ready === 1'b0, "R7 partial not ready", int'(rd_cell_ready), 0);
    get_none("R7 partial not readable");
    put_cell(16'h404, 4, -1, 1);
    settle();
    check(rd_cell_ready === 1'b1, "R7 completed cell ready", int'(rd_cell_ready), 1);
    get_words(16'h400, 8, "R7 completed cell data");
  endtask

  task automatic t_fill();
    for (int c = 0; c < 7; c++) put_cell(16'h1000 + c * 16, 8, -1, 1);
    settle();
    check(wr_space === 1'b1, "R6 space with one cell free", int'(wr_space), 1);
    put_cell(16'h1000 + 7 * 16, 8, -1, 1);
    settle();
    check(wr_space === 1'b0, "R6 no space when full", int'(wr_space), 0);
    put_cell(16'hBEEF, 1, -1, 1);
    settle();
    for (int c = 0; c < 8; c++) get_words(16'h1000 + c * 16, 8, "R3 R1 drain full store");
    get_none("R3 overflow word ignored");
    settle();
    check(wr_space === 1'b1, "R6 space after drain", int'(wr_space), 1);
    check(rd_cell_ready === 1'b0, "R5 empty after drain", int'(rd_cell_ready), 0);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 16; i++) begin
      @(negedge wr_clk);
      wr_en = 1; wr_data = DATA_W'(16'h500 + i);
      wr_eoc = (i == 7) || (i == 15); wr_drop = 0;
    end
    @(negedge wr_clk); wr_en = 0; wr_eoc = 0;
    settle();
    get_words(16'h500, 8, "R1 first of back-to-back");
    settle();
    check(rd_cell_ready === 1'b1, "R5 second cell still ready", int'(rd_cell_ready), 1);
    get_words(16'h508, 8, "R1 second of back-to-back");
  endtask

  task automatic t_bigger_cell();
    rst = 1;
    repeat (4) @(negedge rd_clk);
    cell_bytes = 8'd32;
    rst = 0;
    settle();
    put_cell(16'h600, 8, -1, 1);
    settle();
    check(rd_cell_ready === 1'b0, "R5 8 words below 16-word cell", int'(rd_cell_ready), 0);
    put_cell(16'h608, 8, -1, 1);
    settle();
    check(rd_cell_ready === 1'b1, "R5 16 words make a cell", int'(rd_cell_ready), 1);
    get_words(16'h600, 16, "R1 32-byte cell data");
  endtask

  initial begin
    t_reset();
    t_single_cell();
    t_drop();
    t_partial();
    t_fill();
    t_back_to_back();
    t_bigger_cell();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule